// File: doc/BRIEF.md
# ISA-Style I/O Target Interface

This block is the peripheral side of an ISA-style expansion bus for I/O cycles. It captures the bus address while the address-latch strobe is high during a processor cycle. It checks whether that address falls in a small aligned I/O window, which is eight bytes at 0x0300 by default. The result of that check drives the active-low 16-bit select output. A bank of 16-bit registers sits behind the window, one register per even byte address.

The address-enable input marks DMA cycles. While it is high, the target does not decode, does not drive the data bus and does not write. On a processor read, the block enables its read data for as long as the read strobe is low. On a processor write, it holds the bus data while the write strobe is low. It commits that data once the strobe's rising edge has passed through a two-flop synchroniser.

To stretch a slow access, the channel-ready output goes low in the same cycle that a decoded strobe goes low. It stays low for a set number of bus clocks. A guard counter always releases it after at most about 2.5 µs, which is 37 clocks at 67 ns.

The pins are plain control signals, not valid/ready streams. The only back-pressure is the channel-ready line. The host must not end its strobe until ready has returned high. The write data must stay stable while the write strobe is low.

Top module: `isa_tgt_top`

## Requirements
- R1: The address is captured on each clock edge where the address-latch strobe is high and address-enable is low. A latch strobe during a DMA cycle (address-enable high) leaves the captured address unchanged.
- R2: `cs16_n` is low exactly when the captured address bits [15:3] equal BASE[15:3] and address-enable is low. The read and write strobes do not affect it.
- R3: While address-enable is high, the block ignores the strobes. `rdata_oe` stays low, `chan_rdy` stays high, and no register is written.
- R4: `rdata_oe` is high only while `cs16_n` and `ior_n` are both low. While it is high, `rdata` carries the register selected by captured address bits [2:1].
- R5: When a decoded strobe goes low, `chan_rdy` goes low in that same cycle. It then stays low for exactly WAIT_STATES rising clock edges and returns high until the strobe is released.
- R6: `chan_rdy` is never low for more than LIMIT consecutive clock edges (default 37), however large WAIT_STATES is.
- R7: A decoded write updates the register selected by address bits [2:1] with the data held during the strobe. The update lands within three clock edges after `iow_n` rises.
- R8: After reset, all registers read 0, `cs16_n` and `chan_rdy` are high, and `rdata_oe` is low.
- R9: A write to an address outside the window changes no register and does not pull `chan_rdy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | I/O address from the bus |
| ale | input | 1 | Address-latch strobe, high marks a valid address |
| aen | input | 1 | Address enable; high marks a DMA cycle |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| wdata | input | 16 | Write data from the bus |
| rdata | output | 16 | Read data toward the bus |
| rdata_oe | output | 1 | Drive enable for rdata; low means the bus is released |
| cs16_n | output | 1 | Active-low 16-bit I/O select from address decode |
| chan_rdy | output | 1 | Channel ready; low inserts wait states |

## Verification
Four rules are checked on every cycle. The read enable must only appear with a decoded read. DMA cycles must stay quiet. Ready may only be low under a decoded strobe. Ready's low run must end at its expected length and never pass the guard limit. Some behaviour only the directed scenarios can show. These are the register contents after writes, which of the four registers a write lands in, the address surviving a DMA latch strobe, out-of-window writes being dropped, and the guard cutting off a wait setting larger than the limit.

// File: rtl/isa_tgt_pkg.sv
package isa_tgt_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_WAIT = 2'd1,
    WS_DONE = 2'd2
  } wait_state_e;

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/isa_tgt_decode.sv
module isa_tgt_decode #(
  parameter int          AW       = 16,
  parameter int          WIN_BITS = 3,
  parameter logic [15:0] BASE     = 16'h0300,
  localparam int         IW       = WIN_BITS - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          ale,
  input  logic          aen,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [AW-1:0] addr_q;

  // capture only during processor cycles
  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (ale && !aen) addr_q <= bus_addr;
  end

  assign hit = !aen && (addr_q[AW-1:WIN_BITS] == BASE[AW-1:WIN_BITS]);
  assign idx = addr_q[WIN_BITS-1:1];
endmodule

// File: rtl/isa_tgt_wait.sv
module isa_tgt_wait
  import isa_tgt_pkg::*;
#(
  parameter int WAIT_STATES = 4,
  parameter int LIMIT       = 37,
  localparam int EFF        = min_int(WAIT_STATES, LIMIT),
  localparam int CW         = $clog2(WAIT_STATES + 2),
  localparam int GW         = $clog2(LIMIT + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  output logic rdy
);
  generate
    if (EFF == 0) begin : g_nowait
      assign rdy = 1'b1;
    end else begin : g_wait
      wait_state_e st_q;
      logic [CW-1:0] cnt_q;
      logic [GW-1:0] guard_q;
      logic          expire;

      assign expire = (int'(cnt_q) + 1 >= WAIT_STATES) ||
                      (int'(guard_q) + 1 >= LIMIT);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_q    <= WS_IDLE;
          cnt_q   <= '0;
          guard_q <= '0;
        end else begin
          unique case (st_q)
            WS_IDLE: if (cmd) begin
              cnt_q   <= CW'(1);
              guard_q <= GW'(1);
              st_q    <= (EFF == 1) ? WS_DONE : WS_WAIT;
            end
            WS_WAIT: begin
              if (!cmd) st_q <= WS_IDLE;
              else if (expire) st_q <= WS_DONE;
              else begin
                cnt_q   <= cnt_q + CW'(1);
                guard_q <= guard_q + GW'(1);
              end
            end
            WS_DONE: if (!cmd) st_q <= WS_IDLE;
            default: st_q <= WS_IDLE;
          endcase
        end
      end

      assign rdy = !(cmd && (st_q == WS_IDLE || st_q == WS_WAIT));
    end
  endgenerate
endmodule

// File: rtl/isa_tgt_regs.sv
module isa_tgt_regs #(
  parameter int  DW    = 16,
  parameter int  NREGS = 4,
  localparam int IW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iow_n,
  input  logic [DW-1:0] wdata,
  input  logic          hit,
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] bank_q [NREGS];
  logic [DW-1:0] hold_q;
  logic [IW-1:0] hold_idx_q;
  logic          hold_hit_q;
  logic [2:0]    wsync_q;
  logic          commit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_idx_q <= '0;
      hold_hit_q <= 1'b0;
      wsync_q    <= '0;
    end else begin
      wsync_q <= {wsync_q[1:0], ~iow_n};
      if (!iow_n) begin
        hold_q     <= wdata;
        hold_idx_q <= idx;
        hold_hit_q <= hit;
      end
    end
  end

  // synchronised rising edge of the write strobe
  assign commit = wsync_q[2] && !wsync_q[1] && hold_hit_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) bank_q[i] <= '0;
      else if (commit && hold_idx_q == IW'(i)) bank_q[i] <= hold_q;
    end
  end

  assign rd_word = bank_q[idx];
endmodule

// File: rtl/isa_tgt_top.sv
module isa_tgt_top #(
  parameter logic [15:0] BASE        = 16'h0300,
  parameter int          WIN_BITS    = 3,
  parameter int          WAIT_STATES = 4,
  parameter int          LIMIT       = 37,
  localparam int         NREGS       = 2 ** (WIN_BITS - 1),
  localparam int         IW          = WIN_BITS - 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        ale,
  input  logic        aen,
  input  logic        ior_n,
  input  logic        iow_n,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        rdata_oe,
  output logic        cs16_n,
  output logic        chan_rdy
);
  logic          hit;
  logic [IW-1:0] idx;
  logic [15:0]   rd_word;
  logic          cmd;

  isa_tgt_decode #(.AW(16), .WIN_BITS(WIN_BITS), .BASE(BASE)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .ale(ale), .aen(aen),
    .hit(hit), .idx(idx)
  );

  assign cmd = hit && (!ior_n || !iow_n);

  isa_tgt_wait #(.WAIT_STATES(WAIT_STATES), .LIMIT(LIMIT)) u_wait (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .rdy(chan_rdy)
  );

  isa_tgt_regs #(.DW(16), .NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .iow_n(iow_n), .wdata(wdata),
    .hit(hit), .idx(idx), .rd_word(rd_word)
  );

  assign cs16_n   = !hit;
  assign rdata_oe = hit && !ior_n;
  assign rdata    = rdata_oe ? rd_word : '0;
endmodule

// File: rtl/isa_tgt_chk.sv
module isa_tgt_chk
  import isa_tgt_pkg::*;
#(
  parameter int  WAIT_STATES = 4,
  parameter int  LIMIT       = 37,
  localparam int EFF         = min_int(WAIT_STATES, LIMIT)
) (
  input logic clk,
  input logic rst_n,
  input logic aen,
  input logic ior_n,
  input logic iow_n,
  input logic rdata_oe,
  input logic cs16_n,
  input logic chan_rdy
);
  int low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= 0;
    else if (!chan_rdy) low_run <= low_run + 1;
    else low_run <= 0;
  end

  p_oe_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (!ior_n && !cs16_n));

  p_dma_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> (chan_rdy && !rdata_oe && cs16_n));

  p_wait_needs_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_rdy |-> (!cs16_n && (!ior_n || !iow_n)));

  p_release_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (EFF > 0 && low_run == EFF) |-> chan_rdy);

  p_guard_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= LIMIT);
endmodule

bind isa_tgt_top isa_tgt_chk #(.WAIT_STATES(WAIT_STATES), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
  .rdata_oe(rdata_oe), .cs16_n(cs16_n), .chan_rdy(chan_rdy)
);

// File: tb/tb_isa_tgt_top.sv
`timescale 1ns/1ps
module tb_isa_tgt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        ale = 1'b0, aen = 1'b0, ior_n = 1'b1, iow_n = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, rdata_s;
  logic        rdata_oe, cs16_n, chan_rdy;
  logic        oe_s, cs_s, rdy_s;
  int          errors = 0;
  int          checks = 0;

  always #5 clk = ~clk;

  isa_tgt_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .ale(ale), .aen(aen),
    .ior_n(ior_n), .iow_n(iow_n), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .cs16_n(cs16_n), .chan_rdy(chan_rdy)
  );

  isa_tgt_top #(.WAIT_STATES(60)) dut_slow (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .ale(ale), .aen(aen),
    .ior_n(ior_n), .iow_n(iow_n), .wdata(wdata), .rdata(rdata_s),
    .rdata_oe(oe_s), .cs16_n(cs_s), .chan_rdy(rdy_s)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic latch(input logic [15:0] a, input logic dma);
    @(negedge clk); bus_addr = a; aen = dma; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
  endtask

  // read at the latched address, return data and count of wait edges
  task automatic bus_read(output logic [15:0] d, output int waits);
    @(negedge clk); ior_n = 1'b0; #1;
    d = rdata; waits = 0;
    while (!chan_rdy && waits < 100) begin
      @(posedge clk); #1; waits++;
    end
    @(negedge clk); ior_n = 1'b1;
  endtask

  task automatic bus_write(input logic [15:0] d, output int waits);
    @(negedge clk); wdata = d; iow_n = 1'b0; #1;
    waits = 0;
    while (!chan_rdy && waits < 100) begin
      @(posedge clk); #1; waits++;
    end
    @(negedge clk); iow_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d; int w;
    #1;
    chk("R8 cs16_n", cs16_n, 1); chk("R8 chan_rdy", chan_rdy, 1);
    chk("R8 rdata_oe", rdata_oe, 0);
    for (int i = 0; i < 4; i++) begin
      latch(16'h0300 + 16'(2 * i), 1'b0);
      bus_read(d, w);
      chk("R8 reg zero", d, 0);
    end
  endtask

  task automatic t_decode();
    latch(16'h0304, 1'b0); #1;
    chk("R2 in window", cs16_n, 0);
    chk("R2 no strobe oe", rdata_oe, 0);
    @(negedge clk); iow_n = 1'b1; ior_n = 1'b1; #1;
    chk("R2 strobe independent", cs16_n, 0);
    latch(16'h0308, 1'b0); #1;
    chk("R2 above window", cs16_n, 1);
    latch(16'h02FE, 1'b0); #1;
    chk("R2 below window", cs16_n, 1);
  endtask

  task automatic t_write_read();
    logic [15:0] d; int w;
    for (int i = 0; i < 4; i++) begin
      latch(16'h0300 + 16'(2 * i), 1'b0);
      bus_write(16'hA5C0 + 16'(i), w);
      chk("R5 write waits", w, 4);
    end
    for (int i = 3; i >= 0; i--) begin
      latch(16'h0300 + 16'(2 * i), 1'b0);
      @(negedge clk); ior_n = 1'b0; #1;
      chk("R4 oe during read", rdata_oe, 1);
      chk("R5 ready low same cycle", chan_rdy, 0);
      @(negedge clk); ior_n = 1'b1; #1;
      chk("R4 oe released", rdata_oe, 0);
      @(negedge clk);
      bus_read(d, w);
      chk("R7 reg by addr bits 2:1", d, 32'hA5C0 + i);
      chk("R5 read waits", w, 4);
    end
  endtask

  task automatic t_dma();
    logic [15:0] d; int w;
    latch(16'h0302, 1'b0);
    latch(16'h0306, 1'b1); #1;
    chk("R3 cs16 high in dma", cs16_n, 1);
    @(negedge clk); ior_n = 1'b0; #1;
    chk("R3 no oe in dma", rdata_oe, 0);
    chk("R3 ready high in dma", chan_rdy, 1);
    @(negedge clk); ior_n = 1'b1;
    bus_write(16'hDEAD, w);
    chk("R3 no wait on dma write", w, 0);
    @(negedge clk); aen = 1'b0; #1;
    chk("R1 address kept over dma ale", cs16_n, 0);
    bus_read(d, w);
    chk("R1 old register read", d, 16'hA5C1);
    latch(16'h0306, 1'b0);
    bus_read(d, w);
    chk("R3 dma write dropped", d, 16'hA5C3);
  endtask

  task automatic t_outside();
    logic [15:0] d; int w;
    latch(16'h0200, 1'b0);
    @(negedge clk); wdata = 16'h1234; iow_n = 1'b0; #1;
    chk("R9 ready high outside", chan_rdy, 1);
    @(negedge clk); iow_n = 1'b1;
    repeat (4) @(negedge clk);
    latch(16'h0300, 1'b0);
    bus_read(d, w);
    chk("R9 reg unchanged", d, 16'hA5C0);
  endtask

  task automatic t_guard();
    int n;
    latch(16'h0300, 1'b0);
    @(negedge clk); ior_n = 1'b0; #1;
    chk("R6 slow ready low", rdy_s, 0);
    n = 0;
    while (!rdy_s && n < 100) begin
      @(posedge clk); #1; n++;
    end
    chk("R6 guard length", n, 37);
    @(negedge clk); ior_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_write_read();
    t_dma();
    t_outside();
    t_guard();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule